// File: doc/BRIEF.md
# Third-Order Multibit Noise Shaper

This block is the digital core of an oversampled audio converter. It takes a 24-bit two's-complement sample, already held or interpolated up to the shaper rate, and turns it into a coarse level code from −11 to +11. A segmented output array then converts that code. The noise transfer function is (1 − z⁻¹)³, so nearly all of the rounding error is pushed out of the audio band. The shaper updates once per `en` pulse, and `en` arrives at the word rate times the internal oversampling factor. Between pulses the level code stays put.

The loop is a chain of three integrators. Each integrator accumulates the difference between the input and the fed-back level. The quantizer sees the input plus all three integrator states. Each quantizer step is a power of two (2^`STEP_SHIFT`), so rounding, feedback and scaling use only shifts and adds. With the default step of 2^20, a full-scale input corresponds to ±8 levels. That leaves headroom up to ±11 for the shaped noise. The integrators are wider than the input and saturate, so an oversized input pins the output instead of wrapping the loop state.

Top module: `ns3_shaper`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the state and drives `level` to 0. From that state, enables with a zero sample keep `level` at 0.
- R2: `level` is a two's-complement code and always lies in −11..+11.
- R3: `level` changes only on a clock edge where `en` is high. Whatever value `sample` has on other cycles does not affect it.
- R4: If the loop has seen only in-range inputs since reset, every update satisfies |level·2^STEP_SHIFT − sample| ≤ 4·2^STEP_SHIFT.
- R5: Since reset, the running sum of (level·2^STEP_SHIFT − sample) over all updates stays within ±2·2^STEP_SHIFT. This is the DC accuracy of the loop.
- R6: When the input is held far enough beyond the range that the output saturates, `level` stays at +11 (positive input) or −11 (negative input) on every update. The integrators saturate and never wrap, so the output never reverses.
- R7: When `rst` and `en` are both high in the same cycle, reset wins and `level` becomes 0.
- R8: The first update after reset gives `level` = floor((sample + 2^(STEP_SHIFT−1)) / 2^STEP_SHIFT), which is rounding half up, limited to ±11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Shaper-rate update enable |
| sample | input | IN_W | Two's-complement input sample |
| level | output | LVL_W | Signed quantized level, −11..+11 |

## Verification
A reset and a shaper update can land on the same edge. The bench provokes this by first driving a large DC input until `level` is clearly nonzero, then raising `rst` and `en` together with a nonzero sample. Reset must win: the output must read 0 afterwards, not the next quantized value. Saturation of the quantizer and of the integrators also coincide. A second instance with a smaller step is driven to a sustained overload of each polarity, and the output must stay pinned at the matching rail on every update.

// File: rtl/ns3_shaper.sv
module ns3_shaper #(
  parameter int IN_W       = 24,
  parameter int STEP_SHIFT = IN_W - 4,
  parameter int LMAX       = 11,
  parameter int GUARD      = 3,
  parameter int LVL_W      = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [IN_W-1:0]  sample,
  output logic signed [LVL_W-1:0] level
);
  localparam int IW = IN_W + GUARD;
  localparam int UW = IW + 2;
  localparam logic signed [UW-1:0] RAIL_HI = UW'((64'sd1 <<< (IW - 1)) - 64'sd1);
  localparam logic signed [UW-1:0] RAIL_LO = UW'(-(64'sd1 <<< (IW - 1)));
  localparam logic signed [UW-1:0] HALF    = UW'(64'sd1 <<< (STEP_SHIFT - 1));
  localparam logic signed [UW-1:0] QTOP    = UW'(LMAX);
  localparam logic signed [UW-1:0] QBOT    = UW'(-LMAX);

  logic signed [IW-1:0]    i1, i2, i3, n1, n2, n3;
  logic signed [UW-1:0]    u, q, qc, err;
  logic signed [LVL_W-1:0] lvl_d;

  function automatic logic signed [IW-1:0] clip(input logic signed [UW-1:0] v);
    if (v > RAIL_HI) return RAIL_HI[IW-1:0];
    if (v < RAIL_LO) return RAIL_LO[IW-1:0];
    return v[IW-1:0];
  endfunction

  assign u     = UW'(sample) + UW'(i1) + UW'(i2) + UW'(i3);
  assign q     = (u + HALF) >>> STEP_SHIFT;
  assign qc    = (q > QTOP) ? QTOP : ((q < QBOT) ? QBOT : q);
  assign lvl_d = qc[LVL_W-1:0];
  assign err   = UW'(sample) - (qc <<< STEP_SHIFT);
  assign n1    = clip(UW'(i1) + err);
  assign n2    = clip(UW'(i2) + UW'(n1));
  assign n3    = clip(UW'(i3) + UW'(n2));

  always_ff @(posedge clk) begin
    if (rst) begin
      i1    <= '0;
      i2    <= '0;
      i3    <= '0;
      level <= '0;
    end else if (en) begin
      i1    <= n1;
      i2    <= n2;
      i3    <= n3;
      level <= lvl_d;
    end
  end

  // R2
  level_range_chk: assert property (@(posedge clk) disable iff (rst)
    (level >= -LMAX) && (level <= LMAX));

  // R3
  level_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(level));

  // R1 R7
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (level == '0));

  // R1
  zero_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (en && sample == '0 && i1 == '0 && i2 == '0 && i3 == '0) |=> (level == '0));
endmodule

// File: tb/ns3_shaper_test.sv
`timescale 1ns/1ps
module ns3_shaper_test;
  localparam int W  = 12;
  localparam int S  = 8;
  localparam int SO = 7;
  localparam int STEP = 1 << S;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic signed [W-1:0] x = '0;
  logic signed [4:0] lv, lvo;
  int runs = 0;
  int fails = 0;
  int acc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ns3_shaper #(.IN_W(W), .STEP_SHIFT(S)) uut (
    .clk(clk), .rst(rst), .en(en), .sample(x), .level(lv));
  ns3_shaper #(.IN_W(W), .STEP_SHIFT(SO)) uut_ovl (
    .clk(clk), .rst(rst), .en(en), .sample(x), .level(lvo));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int xv, input bit e);
    x  = W'(xv);
    en = e;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    en  = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    acc = 0;
  endtask

  task automatic tracked(input int xv);
    int d;
    cyc(xv, 1'b1);
    d = int'(lv) * STEP - xv;
    acc += d;
    chk(int'(lv) >= -11 && int'(lv) <= 11, "R2 range", int'(lv), 0);
    chk(d <= 4 * STEP && d >= -4 * STEP, "R4 per-update error", d, 0);
    chk(acc <= 2 * STEP && acc >= -2 * STEP, "R5 running sum", acc, 0);
  endtask

  initial begin
    int ex, prev;
    @(negedge clk);
    do_reset();
    chk(lv == 0, "R1 reset level", int'(lv), 0);
    chk(lvo == 0, "R1 reset level ovl", int'(lvo), 0);
    repeat (16) begin
      cyc(0, 1'b1);
      chk(lv == 0, "R1 zero input idle", int'(lv), 0);
    end

    for (int xv = -2048; xv <= 2047; xv++) begin
      do_reset();
      tracked(xv);
      ex = (xv + STEP / 2) >>> S;
      if (ex > 11) ex = 11;
      if (ex < -11) ex = -11;
      chk(int'(lv) == ex, "R8 first update", int'(lv), ex);
      repeat (12) tracked(xv);
    end

    do_reset();
    for (int k = 0; k < 800; k++) begin
      int xv;
      xv = ((k * 37) % 4096) - 2048;
      if (k % 4 == 0) tracked(xv);
      else begin
        prev = int'(lv);
        cyc(-xv, 1'b0);
        chk(int'(lv) == prev, "R3 hold without enable", int'(lv), prev);
      end
    end

    do_reset();
    for (int k = 0; k < 300; k++) tracked((k % 2 == 0) ? 2000 : -2000);

    do_reset();
    repeat (5) tracked(2000);
    chk(lv != 0, "R7 precondition nonzero", int'(lv), 8);
    rst = 1'b1;
    en  = 1'b1;
    x   = W'(2000);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    en  = 1'b0;
    chk(lv == 0, "R7 reset over enable", int'(lv), 0);

    do_reset();
    repeat (200) begin
      cyc(2047, 1'b1);
      chk(lvo == 11, "R6 positive overload", int'(lvo), 11);
    end
    do_reset();
    repeat (200) begin
      cyc(-2048, 1'b1);
      chk(lvo == -11, "R6 negative overload", int'(lvo), -11);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      runs++;
      fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run complete)");
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule